// File: doc/BRIEF.md
# Prioritised DMA Request Arbiter

This block chooses which DMA channel the transfer engine serves next. Every channel has two level-sensitive request lines from its peripheral: a single-transfer request and a burst request. Software can also raise a request on any channel with a one-cycle pulse. Per-channel attribute vectors decide whether a channel takes part at all (enable), whether its peripheral lines are ignored (mask), whether single requests are ignored (burst-only), and which of two priority levels it belongs to.

When the engine reports idle and the global enable is set, the arbiter issues a one-cycle grant. The grant carries the winning channel number and a flag that says whether the engine should run a full burst or a single transfer. Software requests are remembered per channel until that channel is granted. Peripheral requests are not stored, so a line that drops before it is served is forgotten.

Top module: `dma_req_arbiter`

## Requirements
- R1: A grant (`grant_valid` high for exactly one cycle) is registered on a clock edge only if `master_en` and `eng_idle` were high and `grant_valid` was low at that edge. Two grants are therefore never in consecutive cycles.
- R2: A channel with its `ch_enable` bit low is never granted. A software request that is pending on it stays pending and is served once the channel is enabled.
- R3: When a channel's `use_burst` bit is 1, its `sreq` line has no effect.
- R4: When a channel's `use_burst` bit is 0, an `sreq` alone gives a grant with `grant_burst` = 0. A `breq` gives `grant_burst` = 1, and so does a `breq` together with an `sreq`.
- R5: When a channel's `req_mask` bit is 1, both its `sreq` and its `breq` lines have no effect.
- R6: A pending software request is granted even when the channel's `req_mask` bit is 1, and it is always reported with `grant_burst` = 1.
- R7: An eligible channel whose `hi_prio` bit is 1 wins over every eligible channel whose `hi_prio` bit is 0.
- R8: Among eligible channels at the same priority level, the lowest channel number wins.
- R9: A pulse on bit c of `sw_req` makes channel c pending from the next cycle. The pending state lasts until channel c is granted. A new pulse that arrives in the cycle of that grant leaves the channel pending again.
- R10: Bits of `sw_req` at positions NUM_CH and above have no effect.
- R11: Peripheral request lines are not latched. A `breq` or `sreq` that is removed before a grant is possible produces no grant.
- R12: While and right after reset, `grant_valid`, `grant_ch` and `grant_burst` are 0 and no software request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_en | input | 1 | Global enable for granting |
| eng_idle | input | 1 | Transfer engine can accept a new channel |
| ch_enable | input | NUM_CH | Per-channel enable |
| req_mask | input | NUM_CH | Per-channel mask of the peripheral request lines |
| use_burst | input | NUM_CH | Per-channel burst-only attribute |
| hi_prio | input | NUM_CH | Per-channel high priority level |
| sreq | input | NUM_CH | Peripheral single-transfer request levels |
| breq | input | NUM_CH | Peripheral burst request levels |
| sw_req | input | SW_BITS | Software request pulses, one bit per channel position |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_ch | output | clog2(NUM_CH) | Granted channel number |
| grant_burst | output | 1 | 1 = burst transfer, 0 = single transfer |

## Verification
The checker keeps a copy of the inputs from the previous edge and assumes that the attribute vectors and request lines are plain levels, sampled once per clock, with no relation between them. It assumes nothing about how long a request is held. Its burst-request and level checks only look at peripheral burst lines, because software pending state is not visible at the ports. The bench drives every input at the falling edge and holds it for a full cycle. It keeps `eng_idle` low between trials, so that each trial starts with `grant_valid` low and with no software request pending unless the trial means to create one.

// File: rtl/dra_pkg.sv
package dra_pkg;

   typedef enum logic {
      XFER_SINGLE = 1'b0,
      XFER_BURST  = 1'b1
   } xfer_kind_e;

   localparam int unsigned MAX_CHANNELS = 32;

endpackage

// File: rtl/dra_sw_pend.sv
// Per-channel software request holding flops.
module dra_sw_pend #(
   parameter int unsigned NUM_CH  = 24,
   parameter int unsigned SW_BITS = 32,
   localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SW_BITS-1:0] sw_req,
   input  logic              grant_fire,
   input  logic [CH_W-1:0]   grant_ch,
   output logic [NUM_CH-1:0] pend
);

   logic [NUM_CH-1:0] sw_in;

   // Only positions that map to an implemented channel are used.
   generate
      if (SW_BITS > NUM_CH) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^sw_req[SW_BITS-1:NUM_CH];
         assign sw_in     = sw_req[NUM_CH-1:0];
      end else if (SW_BITS == NUM_CH) begin : g_exact
         assign sw_in = sw_req;
      end else begin : g_narrow
         assign sw_in = {{(NUM_CH-SW_BITS){1'b0}}, sw_req};
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic served;
         assign served = grant_fire && (grant_ch == CH_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend[g] <= 1'b0;
            end else if (sw_in[g]) begin
               pend[g] <= 1'b1;
            end else if (served) begin
               pend[g] <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dra_qualify.sv
// Applies the per-channel attributes to the raw request sources.
module dra_qualify #(
   parameter int unsigned NUM_CH = 24
) (
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic [NUM_CH-1:0] req_mask,
   input  logic [NUM_CH-1:0] use_burst,
   input  logic [NUM_CH-1:0] sreq,
   input  logic [NUM_CH-1:0] breq,
   input  logic [NUM_CH-1:0] sw_pend,
   output logic [NUM_CH-1:0] elig,
   output logic [NUM_CH-1:0] want_burst
);
   import dra_pkg::*;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic ext_burst;
         logic ext_single;
         xfer_kind_e kind;

         assign ext_burst  = breq[g] & ~req_mask[g];
         assign ext_single = sreq[g] & ~req_mask[g] & ~use_burst[g];
         assign kind       = (ext_burst | sw_pend[g]) ? XFER_BURST : XFER_SINGLE;
         assign elig[g]       = ch_enable[g] & (ext_burst | ext_single | sw_pend[g]);
         assign want_burst[g] = (kind == XFER_BURST);
      end
   endgenerate

endmodule

// File: rtl/dra_lowest.sv
// Finds the lowest set bit of a vector.
module dra_lowest #(
   parameter int unsigned N = 24,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/dra_pick.sv
// Two-level selection: high level first, then the default level.
module dra_pick #(
   parameter int unsigned NUM_CH = 24,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] elig,
   input  logic [NUM_CH-1:0] hi_prio,
   output logic              win_found,
   output logic [CH_W-1:0]   win_ch
);

   logic [NUM_CH-1:0] lvl_vec [2];
   logic              lvl_found [2];
   logic [CH_W-1:0]   lvl_idx [2];

   assign lvl_vec[0] = elig & ~hi_prio;
   assign lvl_vec[1] = elig &  hi_prio;

   generate
      for (genvar l = 0; l < 2; l++) begin : g_lvl
         dra_lowest #(.N(NUM_CH)) u_low (
            .vec   (lvl_vec[l]),
            .found (lvl_found[l]),
            .idx   (lvl_idx[l])
         );
      end
   endgenerate

   assign win_found = lvl_found[1] | lvl_found[0];
   assign win_ch    = lvl_found[1] ? lvl_idx[1] : lvl_idx[0];

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
   parameter int unsigned NUM_CH  = 24,
   parameter int unsigned SW_BITS = 32,
   localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               master_en,
   input  logic               eng_idle,
   input  logic [NUM_CH-1:0]  ch_enable,
   input  logic [NUM_CH-1:0]  req_mask,
   input  logic [NUM_CH-1:0]  use_burst,
   input  logic [NUM_CH-1:0]  hi_prio,
   input  logic [NUM_CH-1:0]  sreq,
   input  logic [NUM_CH-1:0]  breq,
   input  logic [SW_BITS-1:0] sw_req,
   output logic               grant_valid,
   output logic [CH_W-1:0]    grant_ch,
   output logic               grant_burst
);

   generate
      if (NUM_CH < 2 || NUM_CH > dra_pkg::MAX_CHANNELS) begin : g_bad_num_ch
         $error("dma_req_arbiter: NUM_CH out of range");
      end
      if (SW_BITS < 1) begin : g_bad_sw_bits
         $error("dma_req_arbiter: SW_BITS must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0] sw_pend;
   logic [NUM_CH-1:0] elig;
   logic [NUM_CH-1:0] want_burst;
   logic              win_found;
   logic [CH_W-1:0]   win_ch;
   logic              fire;

   // One idle cycle after every grant lets the engine drop eng_idle.
   assign fire = master_en & eng_idle & ~grant_valid & win_found;

   dra_sw_pend #(.NUM_CH(NUM_CH), .SW_BITS(SW_BITS)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_req     (sw_req),
      .grant_fire (fire),
      .grant_ch   (win_ch),
      .pend       (sw_pend)
   );

   dra_qualify #(.NUM_CH(NUM_CH)) u_qual (
      .ch_enable  (ch_enable),
      .req_mask   (req_mask),
      .use_burst  (use_burst),
      .sreq       (sreq),
      .breq       (breq),
      .sw_pend    (sw_pend),
      .elig       (elig),
      .want_burst (want_burst)
   );

   dra_pick #(.NUM_CH(NUM_CH)) u_pick (
      .elig      (elig),
      .hi_prio   (hi_prio),
      .win_found (win_found),
      .win_ch    (win_ch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_ch    <= '0;
         grant_burst <= 1'b0;
      end else begin
         grant_valid <= fire;
         if (fire) begin
            grant_ch    <= win_ch;
            grant_burst <= want_burst[win_ch];
         end
      end
   end

endmodule

// File: rtl/dra_arb_chk.sv
module dra_arb_chk #(
   parameter int unsigned NUM_CH = 24,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_en,
   input logic              eng_idle,
   input logic [NUM_CH-1:0] ch_enable,
   input logic [NUM_CH-1:0] req_mask,
   input logic [NUM_CH-1:0] use_burst,
   input logic [NUM_CH-1:0] hi_prio,
   input logic [NUM_CH-1:0] sreq,
   input logic [NUM_CH-1:0] breq,
   input logic              grant_valid,
   input logic [CH_W-1:0]   grant_ch,
   input logic              grant_burst
);

   logic              p_men, p_idle;
   logic [NUM_CH-1:0] p_en, p_mask, p_ub, p_hi, p_sreq, p_breq;
   logic [NUM_CH-1:0] p_ext_burst, lower, same_lvl;

   always_ff @(posedge clk) begin
      p_men  <= master_en;
      p_idle <= eng_idle;
      p_en   <= ch_enable;
      p_mask <= req_mask;
      p_ub   <= use_burst;
      p_hi   <= hi_prio;
      p_sreq <= sreq;
      p_breq <= breq;
   end

   assign p_ext_burst = p_en & p_breq & ~p_mask;
   assign lower       = (NUM_CH'(1) << grant_ch) - NUM_CH'(1);
   assign same_lvl    = p_hi[grant_ch] ? p_hi : ~p_hi;

   AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (p_men && p_idle)); // R1
   AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |=> !grant_valid); // R1
   AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> p_en[grant_ch]); // R2
   AST_SINGLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !grant_burst) |-> (p_sreq[grant_ch] && !p_ub[grant_ch] && !p_mask[grant_ch])); // R3
   AST_HIGH_LEVEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !p_hi[grant_ch]) |-> ((p_ext_burst & p_hi) == '0)); // R7
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ((p_ext_burst & lower & same_lvl) == '0)); // R8

endmodule

bind dma_req_arbiter dra_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .master_en   (master_en),
   .eng_idle    (eng_idle),
   .ch_enable   (ch_enable),
   .req_mask    (req_mask),
   .use_burst   (use_burst),
   .hi_prio     (hi_prio),
   .sreq        (sreq),
   .breq        (breq),
   .grant_valid (grant_valid),
   .grant_ch    (grant_ch),
   .grant_burst (grant_burst)
);

// File: tb/dma_req_arbiter_tb.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb;

   localparam int N  = 6;
   localparam int SB = 8;
   localparam int CW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          master_en, eng_idle;
   logic [N-1:0]  ch_enable, req_mask, use_burst, hi_prio, sreq, breq;
   logic [SB-1:0] sw_req;
   logic          grant_valid;
   logic [CW-1:0] grant_ch;
   logic          grant_burst;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #4 clk = ~clk;

   dma_req_arbiter #(.NUM_CH(N), .SW_BITS(SB)) u_dut (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .eng_idle(eng_idle),
      .ch_enable(ch_enable), .req_mask(req_mask), .use_burst(use_burst),
      .hi_prio(hi_prio), .sreq(sreq), .breq(breq), .sw_req(sw_req),
      .grant_valid(grant_valid), .grant_ch(grant_ch), .grant_burst(grant_burst)
   );

   task automatic clear_inputs();
      master_en = 1'b0; eng_idle = 1'b0;
      ch_enable = '0; req_mask = '0; use_burst = '0; hi_prio = '0;
      sreq = '0; breq = '0; sw_req = '0;
   endtask

   task automatic check_grant(string rq, logic ev, int ech, logic eb);
      checks++;
      if (grant_valid !== ev || (ev && (grant_ch !== CW'(ech) || grant_burst !== eb))) begin
         fails++;
         $display("FAIL %s: got valid=%0b ch=%0d burst=%0b, expected valid=%0b ch=%0d burst=%0b",
                  rq, grant_valid, grant_ch, grant_burst, ev, ech, eb);
      end
   endtask

   // One idle cycle, check the grant, then leave the engine busy for a cycle.
   task automatic idle_trial(string rq, logic ev, int ech, logic eb);
      eng_idle = 1'b1;
      @(negedge clk);
      check_grant(rq, ev, ech, eb);
      eng_idle = 1'b0;
      sw_req   = '0;
      @(negedge clk);
   endtask

   task automatic pulse_sw(logic [SB-1:0] bits);
      sw_req = bits;
      @(negedge clk);
      sw_req = '0;
   endtask

   // Expected winner from the requirements, with no software request pending.
   task automatic expect_winner(output logic v, output int ch, output logic b);
      v = 1'b0; ch = 0; b = 1'b0;
      for (int lvl = 1; lvl >= 0; lvl--) begin
         logic found = 1'b0;
         for (int c = N - 1; c >= 0; c--) begin
            logic eb_ = breq[c] & ~req_mask[c];
            logic es_ = sreq[c] & ~req_mask[c] & ~use_burst[c];
            if (!v && ch_enable[c] && (eb_ || es_) && (hi_prio[c] == lvl[0])) begin
               found = 1'b1; ch = c; b = eb_;
            end
         end
         if (found) v = 1'b1;
      end
      if (!master_en) v = 1'b0;
   endtask

   function automatic logic [31:0] next_rng(logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic ev, eb;
      int   ech;
      clear_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_grant("R12 in reset", 1'b0, 0, 1'b0);
      checks++;
      if (grant_ch !== '0 || grant_burst !== 1'b0) begin
         fails++;
         $display("FAIL R12: got ch=%0d burst=%0b, expected 0 0", grant_ch, grant_burst);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R12: nothing pending after reset.
      master_en = 1'b1; ch_enable = '1; req_mask = '1;
      idle_trial("R12 no pending", 1'b0, 0, 1'b0);

      // R9 + R6: software request held, masked lines do not block it.
      pulse_sw(SB'(1) << 2);
      repeat (3) @(negedge clk);
      idle_trial("R6 sw through mask", 1'b1, 2, 1'b1);
      idle_trial("R9 pending cleared", 1'b0, 0, 1'b0);

      // R2: pending on a disabled channel waits.
      ch_enable = 6'b110111;
      pulse_sw(SB'(1) << 3);
      idle_trial("R2 disabled", 1'b0, 0, 1'b0);
      ch_enable = '1;
      @(negedge clk);
      idle_trial("R2 enabled later", 1'b1, 3, 1'b1);

      // R9: new pulse during the grant cycle keeps the channel pending.
      pulse_sw(SB'(1) << 4);
      sw_req = SB'(1) << 4;
      idle_trial("R9 grant with new pulse", 1'b1, 4, 1'b1);
      idle_trial("R9 repended", 1'b1, 4, 1'b1);
      idle_trial("R9 drained", 1'b0, 0, 1'b0);

      // R10: positions above NUM_CH are ignored.
      pulse_sw(8'hC0);
      idle_trial("R10 unimplemented sw", 1'b0, 0, 1'b0);

      // R11: request removed before idle is forgotten.
      req_mask = '0;
      breq = 6'b000010;
      @(negedge clk);
      breq = '0;
      idle_trial("R11 not latched", 1'b0, 0, 1'b0);

      // R1: idle held high gives grants every other cycle.
      breq = 6'b000001;
      eng_idle = 1'b1;
      @(negedge clk);
      check_grant("R1 first", 1'b1, 0, 1'b1);
      @(negedge clk);
      check_grant("R1 gap", 1'b0, 0, 1'b0);
      @(negedge clk);
      check_grant("R1 second", 1'b1, 0, 1'b1);
      eng_idle = 1'b0;
      @(negedge clk);
      master_en = 1'b0;
      idle_trial("R1 master off", 1'b0, 0, 1'b0);

      // R4: both lines on one channel report burst; single alone reports single.
      master_en = 1'b1; breq = '0; sreq = 6'b000100;
      idle_trial("R4 single", 1'b1, 2, 1'b0);
      breq = 6'b000100;
      idle_trial("R4 both", 1'b1, 2, 1'b1);
      breq = '0; use_burst = 6'b000100;
      idle_trial("R3 single suppressed", 1'b0, 0, 1'b0);
      use_burst = '0;

      // Sweep: R3/R4/R5/R7/R8/R2 over generated attribute patterns.
      for (int i = 0; i < 600; i++) begin
         rng = next_rng(rng); ch_enable = ~(rng[5:0] & rng[11:6]); req_mask = rng[17:12] & rng[23:18];
         use_burst = rng[29:24];
         rng = next_rng(rng); hi_prio = rng[5:0]; sreq = rng[11:6]; breq = rng[17:12] & rng[23:18];
         master_en = (i % 16) != 15;
         expect_winner(ev, ech, eb);
         idle_trial("R3/R4/R5/R7/R8/R2 sweep", ev, ech, eb);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule